// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel's count sits in a low byte and a high byte. One shared 8-bit configuration register sets up both channels, with one nibble per channel. Each nibble picks four things: the counting source, optional gating by an external level, and one of four counter shapes. The shapes are a 13-bit counter with a 5-bit prescaler, a full 16-bit counter, an 8-bit counter that reloads itself, and a split mode. Split mode turns channel 0 into two independent 8-bit counters.

A machine-cycle strobe (`tick_en`) paces all counting. In timer mode a channel advances once per strobe. In event mode it advances once per falling edge seen on its event pin. Software loads and reads the count bytes, the configuration and a control byte through a byte-wide register port. Each channel has a sticky overflow flag. Software can clear a flag through the control byte, or an acknowledge pulse can clear it.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00 and both overflow flags are low.
- R2: Register addresses are: 0 configuration, 1 control, 2/3 channel-0 low/high, 4/5 channel-1 low/high. Configuration bits [3:0] set up channel 0 and bits [7:4] set up channel 1. Inside each nibble the bit order from high to low is gate, event-select, mode[1:0]. Control bit 0 and bit 1 are the run bits of channel 0 and channel 1. Control bit 2 and bit 3 are their overflow flags.
- R3: With event-select 0, a running channel advances once per cycle in which `tick_en` is high. It holds while `tick_en` is low or while its run bit is 0.
- R4: With the gate bit set, a channel advances only while its `gate_pin` (synchronised over two clocks) is high.
- R5: With event-select 1, a channel advances once per high-to-low change of its synchronised `evt_pin`, where the pin is compared across successive `tick_en` samples. Rising changes do not advance it.
- R6: Mode 1 chains high:low into one 16-bit counter. Stepping from 0xFFFF to 0x0000 sets the channel's flag.
- R7: Mode 0 counts in low bits [4:0] as a prescaler, and each wrap of those bits advances the high byte. Low bits [7:5] keep their value. Stepping from high 0xFF / low[4:0] 0x1F to zero sets the flag.
- R8: Mode 2 counts in the low byte only. A step from 0xFF loads the high byte into the low byte and sets the flag.
- R9: In mode 3, channel 0's low byte is an 8-bit counter under channel 0's run, gate and source controls, and it sets flag 0. Channel 0's high byte is an 8-bit timer that advances on each tick while channel 1's run bit is set. Its wrap sets flag 1.
- R10: While channel 0 is in mode 3, channel 1 keeps counting in its own mode, but its overflows never set flag 1. Channel 1 set to mode 3 holds its count.
- R11: Flags stay set until a control write with the flag bit at 0 or an `ovf_ack` pulse. An overflow in the same cycle as a clear leaves the flag set.
- R12: A byte write to a channel in a cycle where that channel would count loads the written byte, and the channel does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| evt_pin | input | 2 | External event inputs, one per channel |
| gate_pin | input | 2 | External gate levels, one per channel |
| ovf_ack | input | 2 | Overflow acknowledge pulses, one per channel |
| ovf_flag | output | 2 | Sticky overflow flags |

## Verification
Some properties are checked on every cycle. Counts hold when neither a tick nor a write occurs. The upper three low-byte bits stay fixed in 13-bit mode. The reload loads the high byte and raises the flag. The split high byte steps once per tick under channel 1's run bit. Flag 1 stays quiet while channel 1 runs under a split channel 0, and flags stay sticky.

Other behaviour only the bench scenarios can show. These are the exact counts across carries in each mode, and the gate delay through the synchroniser. They also include counting only falling event edges, the precedence of writes over counting, and the order in which acknowledge, software clear and a new overflow resolve.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_CH   = 2;

  typedef enum logic [1:0] {
    MODE_13B   = 2'd0,
    MODE_16B   = 2'd1,
    MODE_RLD   = 2'd2,
    MODE_SPLIT = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      use_evt;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_lvl
);
  logic [STAGES-1:0][WIDTH-1:0] sh_q, sh_d;

  always_comb begin
    sh_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) sh_d[s] = sh_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pin_lvl = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pair_pkg::*;
#(
  parameter int PRESC_W  = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              hi_run,
  input  logic              gate_lvl,
  input  logic              evt_lvl,
  input  chan_cfg_t         cfg,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_main,
  output logic              ovf_hi
);
  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              evt_prev_q, evt_prev_d;
  logic              evt_fall, chan_en, step, hi_step;
  logic [CW-1:0]     wide_nx;

  assign evt_fall   = tick & evt_prev_q & ~evt_lvl;
  assign evt_prev_d = tick ? evt_lvl : evt_prev_q;
  assign chan_en    = run & (~cfg.gate | gate_lvl);
  assign step       = chan_en & (cfg.use_evt ? evt_fall : tick);
  assign hi_step    = tick & hi_run;
  assign wide_nx    = {hi_q, lo_q} + CW'(1);

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    if (wr_lo || wr_hi) begin
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
    end else begin
      case (cfg.mode)
        MODE_13B: if (step) begin
          if (&lo_q[PRESC_W-1:0]) begin
            lo_d[PRESC_W-1:0] = '0;
            hi_d              = hi_q + BYTE_W'(1);
            ovf_main          = &hi_q;
          end else begin
            lo_d[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + PRESC_W'(1);
          end
        end
        MODE_16B: if (step) begin
          {hi_d, lo_d} = wide_nx;
          ovf_main     = &{hi_q, lo_q};
        end
        MODE_RLD: if (step) begin
          if (&lo_q) begin
            lo_d     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_d = lo_q + BYTE_W'(1);
          end
        end
        default: if (SPLIT_OK) begin
          if (step) begin
            lo_d     = lo_q + BYTE_W'(1);
            ovf_main = &lo_q;
          end
          if (hi_step) begin
            hi_d   = hi_q + BYTE_W'(1);
            ovf_hi = &hi_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      hi_q       <= '0;
      evt_prev_q <= 1'b0;
    end else begin
      lo_q       <= lo_d;
      hi_q       <= hi_d;
      evt_prev_q <= evt_prev_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int PRESC_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [N_CH-1:0]   evt_pin,
  input  logic [N_CH-1:0]   gate_pin,
  input  logic [N_CH-1:0]   ovf_ack,
  output logic [N_CH-1:0]   ovf_flag
);
  localparam int CFG_NIB = 4;

  logic [BYTE_W-1:0]             cfg_q, cfg_d;
  logic [N_CH-1:0]               run_q, run_d, ovf_q, ovf_d;
  logic [N_CH-1:0]               ovf_set, ovf_keep;
  logic [N_CH-1:0]               ch_ovf_main, ch_ovf_hi;
  logic [N_CH-1:0][BYTE_W-1:0]   cnt_lo, cnt_hi;
  logic [2*N_CH-1:0]             pin_lvl;
  logic                          wr_cfg, wr_ctrl, split0;
  chan_cfg_t [N_CH-1:0]          ch_cfg;

  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  tmr_pin_sync #(.WIDTH(2*N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in ({gate_pin, evt_pin}),
    .pin_lvl(pin_lvl)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(A_CNT + 2*i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(A_CNT + 2*i + 1);
    logic hi_run;

    assign ch_cfg[i] = chan_cfg_t'(cfg_q[CFG_NIB*i +: CFG_NIB]);
    assign hi_run    = (i == 0) ? run_q[N_CH-1] : 1'b0;

    tmr_channel #(.PRESC_W(PRESC_W), .SPLIT_OK(i == 0)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .run     (run_q[i]),
      .hi_run  (hi_run),
      .gate_lvl(pin_lvl[N_CH+i]),
      .evt_lvl (pin_lvl[i]),
      .cfg     (ch_cfg[i]),
      .wr_lo   (wr_en && (wr_addr == A_LO)),
      .wr_hi   (wr_en && (wr_addr == A_HI)),
      .wdata   (wr_data),
      .cnt_lo  (cnt_lo[i]),
      .cnt_hi  (cnt_hi[i]),
      .ovf_main(ch_ovf_main[i]),
      .ovf_hi  (ch_ovf_hi[i])
    );
  end

  assign split0     = (ch_cfg[0].mode == MODE_SPLIT);
  assign ovf_set[0] = ch_ovf_main[0];
  assign ovf_set[1] = split0 ? ch_ovf_hi[0] : (ch_ovf_main[1] | ch_ovf_hi[1]);

  always_comb begin
    cfg_d    = wr_cfg ? wr_data : cfg_q;
    run_d    = wr_ctrl ? wr_data[N_CH-1:0] : run_q;
    ovf_keep = wr_ctrl ? wr_data[2*N_CH-1:N_CH] : ovf_q;
    ovf_d    = ovf_set | (ovf_keep & ~ovf_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= '0;
      ovf_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= run_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = cfg_q;
      A_CTRL:  rd_data = BYTE_W'({ovf_q, run_q});
      3'd2:    rd_data = cnt_lo[0];
      3'd3:    rd_data = cnt_hi[0];
      3'd4:    rd_data = cnt_lo[1];
      3'd5:    rd_data = cnt_hi[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pair_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_en,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [N_CH-1:0]             ovf_ack,
  input logic [N_CH-1:0]             ovf_flag,
  input logic [BYTE_W-1:0]           cfg_q,
  input logic [N_CH-1:0]             run_q,
  input logic [N_CH-1:0][BYTE_W-1:0] cnt_lo,
  input logic [N_CH-1:0][BYTE_W-1:0] cnt_hi
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  // R3: no tick and no write -> all counts frozen
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R7: upper three low-byte bits never move in 13-bit mode
  assert_upper_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd0 && !wr_en) |=> $stable(cnt_lo[0][7:5]));

  // R8: reload from high byte with flag on low-byte wrap
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && run_q[0] && cfg_q[3:0] == 4'b0010 && cnt_lo[0] == 8'hFF)
    |=> (cnt_lo[0] == $past(cnt_hi[0]) && ovf_flag[0]));

  // R9: split high byte steps once per tick under channel-1 run
  assert_split_hi_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd3 && tick_en && run_q[1] && !wr_en)
    |=> (cnt_hi[0] == $past(cnt_hi[0]) + 8'd1));

  // R10: channel 1 cannot raise flag 1 while channel 0 is split
  assert_ch1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd3 && cnt_hi[0] != 8'hFF && !ovf_flag[1] && !ctrl_wr)
    |=> !ovf_flag[1]);

  // R11: flag stays set without a clear
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[0] && !ovf_ack[0] && !ctrl_wr) |=> ovf_flag[0]);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ovf_ack (ovf_ack),
  .ovf_flag(ovf_flag),
  .cfg_q   (cfg_q),
  .run_q   (run_q),
  .cnt_lo  (cnt_lo),
  .cnt_hi  (cnt_hi)
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk, rst_n, tick_en, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] evt_pin, gate_pin, ovf_ack, ovf_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tmr_pair u_tmr_pair (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] cfg; logic [7:0] lo; logic [7:0] hi; logic [7:0] n;
    logic [7:0] e_lo; logic [7:0] e_hi; logic e_flag;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'hFE, 8'h12, 8'd3,  8'h01, 8'h13, 1'b0},
    '{8'h01, 8'hFF, 8'hFF, 8'd1,  8'h00, 8'h00, 1'b1},
    '{8'h01, 8'hFE, 8'hFF, 8'd4,  8'h02, 8'h00, 1'b1},
    '{8'h00, 8'hFE, 8'h05, 8'd3,  8'hE1, 8'h06, 1'b0},
    '{8'h00, 8'h1F, 8'hFF, 8'd1,  8'h00, 8'h00, 1'b1},
    '{8'h00, 8'hA0, 8'h00, 8'd40, 8'hA8, 8'h01, 1'b0},
    '{8'h02, 8'hFD, 8'h80, 8'd3,  8'h80, 8'h80, 1'b1},
    '{8'h02, 8'hFF, 8'h10, 8'd5,  8'h14, 8'h10, 1'b1},
    '{8'h03, 8'hFF, 8'h40, 8'd2,  8'h01, 8'h40, 1'b1}
  };

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R7";
      2'd1: return "R6";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, v2;
    rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    rd_addr = 0; evt_pin = 0; gate_pin = 0; ovf_ack = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", {8'h0, v}, 16'h0);
    end
    chk("R1 flags", {14'h0, ovf_flag}, 16'h0);

    // R2: configuration readback and control layout
    wr(3'd0, 8'hA5);
    rd(3'd0, v); chk("R2 cfg", {8'h0, v}, 16'h00A5);
    wr(3'd1, 8'h03);
    rd(3'd1, v); chk("R2 ctrl", {8'h0, v}, 16'h0003);
    wr(3'd1, 8'h00);

    // Vector table: channel 0, timer source
    for (int k = 0; k < NV; k++) begin
      wr(3'd1, 8'h00);
      wr(3'd0, VECS[k].cfg);
      wr(3'd2, VECS[k].lo);
      wr(3'd3, VECS[k].hi);
      wr(3'd1, 8'h01);
      ticks(int'(VECS[k].n));
      rd(3'd2, v); rd(3'd3, v2);
      chk(mode_tag(VECS[k].cfg[1:0]), {v2, v}, {VECS[k].e_hi, VECS[k].e_lo});
      chk(mode_tag(VECS[k].cfg[1:0]), {14'h0, ovf_flag}, {15'h0, VECS[k].e_flag});
    end
    wr(3'd1, 8'h00);

    // R3: hold without tick, hold without run, then count
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    idle(5);
    rd(3'd2, v); chk("R3 no tick", {8'h0, v}, 16'h0010);
    wr(3'd1, 8'h00);
    ticks(5);
    rd(3'd2, v); chk("R3 no run", {8'h0, v}, 16'h0010);
    wr(3'd1, 8'h01);
    ticks(5);
    rd(3'd2, v); chk("R3 count", {8'h0, v}, 16'h0015);

    // R4: gate
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd1, 8'h01);
    ticks(6);
    rd(3'd2, v); chk("R4 gate low", {8'h0, v}, 16'h0000);
    gate_pin[0] = 1'b1; idle(4);
    ticks(6);
    rd(3'd2, v); chk("R4 gate high", {8'h0, v}, 16'h0006);
    gate_pin[0] = 1'b0; idle(4);
    ticks(3);
    rd(3'd2, v); chk("R4 gate dropped", {8'h0, v}, 16'h0006);

    // R5: event source on channel 1
    wr(3'd1, 8'h00); wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h02);
    tick_en = 1'b1;
    for (int e = 0; e < 3; e++) begin
      evt_pin[1] = 1'b1; idle(6);
      evt_pin[1] = 1'b0; idle(6);
    end
    tick_en = 1'b0;
    rd(3'd4, v); chk("R5 falls", {8'h0, v}, 16'h0003);
    evt_pin[1] = 1'b1; ticks(8);
    rd(3'd4, v); chk("R5 rise ignored", {8'h0, v}, 16'h0003);

    // R12: write wins over count
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h20); wr(3'd3, 8'h07);
    wr(3'd1, 8'h01);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h50;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); rd(3'd3, v2); chk("R12 write wins", {v2, v}, 16'h0750);
    ticks(2);
    rd(3'd2, v); chk("R12 resume", {8'h0, v}, 16'h0052);

    // R9/R10: split channel 0, channel 1 in 16-bit mode
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'h33); wr(3'd3, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h02);
    ticks(3);
    rd(3'd3, v); chk("R9 split hi", {8'h0, v}, 16'h0003);
    rd(3'd2, v); chk("R9 split lo idle", {8'h0, v}, 16'h0033);
    rd(3'd4, v); rd(3'd5, v2); chk("R10 ch1 counts", {v2, v}, 16'h0001);
    chk("R10 no flag", {14'h0, ovf_flag}, 16'h0);
    wr(3'd3, 8'hFE);
    ticks(3);
    rd(3'd3, v); chk("R9 split hi wrap", {8'h0, v}, 16'h0001);
    chk("R9 flag1", {14'h0, ovf_flag}, 16'h0002);

    // R10: channel 1 in mode 3 holds
    wr(3'd1, 8'h00); wr(3'd0, 8'h30); wr(3'd4, 8'h44); wr(3'd1, 8'h02);
    ticks(4);
    rd(3'd4, v); chk("R10 ch1 mode3 hold", {8'h0, v}, 16'h0044);
    chk("R10 ch1 mode3 flag", {14'h0, ovf_flag}, 16'h0);

    // R11: sticky flag, clear paths, set wins
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    ticks(1); idle(3);
    chk("R11 sticky", {14'h0, ovf_flag}, 16'h0001);
    rd(3'd1, v); chk("R11 ctrl view", {8'h0, v}, 16'h0005);
    ovf_ack[0] = 1'b1; @(negedge clk); ovf_ack[0] = 1'b0;
    chk("R11 ack clear", {14'h0, ovf_flag}, 16'h0);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    ticks(1);
    wr(3'd1, 8'h01);
    chk("R11 sw clear", {14'h0, ovf_flag}, 16'h0);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    tick_en = 1'b1; ovf_ack[0] = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; ovf_ack[0] = 1'b0;
    chk("R11 set wins", {14'h0, ovf_flag}, 16'h0001);

    finish_run();
  end
endmodule